// File: doc/BRIEF.md
# Object Handle Hash Lookup

This block maps a 32-bit object handle, qualified by a channel number, to a stored context word. The pairs live in an on-chip table of 512 two-word slots held in synchronous RAM. A client either asks for the context of a handle (lookup port) or registers a new handle with its instance address and engine number (insert port). Both operations start at a slot given by a fold-XOR hash of the handle and the channel. From there they walk the table one slot at a time and wrap from the last slot back to the first.

A lookup stops at the first slot whose handle matches, at the first empty slot, or after every slot has been visited. An insert stops at the first empty slot and writes there, or reports that the table is full. After reset the block clears the whole table before it accepts work. The context word layout is chosen at build time. The default layout carries a valid flag and the channel number, and a lookup must match that channel as well as the handle. The alternate layout moves the engine field and matches on the handle alone.

Top module: `obj_hash_lookup`

## Requirements
- R1: The first slot probed is the XOR of the handle's four 9-bit chunks, taken from bit 0 upward with the top chunk zero-padded, XORed with the channel number shifted left by 5 and truncated to 9 bits.
- R2: A slot holds the handle in its upper word and the context word in its lower word. In the default layout the context word is bit 31 = 1, bits 28:24 = channel, bits 17:16 = engine, bits 15:0 = instance address, and all other bits are 0.
- R3: An insert treats a slot with a nonzero handle as occupied and moves to the next slot, going from slot 511 to slot 0. It writes the first empty slot and returns status 0 (ok).
- R4: A lookup that reaches a slot with an equal handle, and in the default layout an equal channel field, returns hit = 1 and that slot's context word.
- R5: A lookup that reaches an empty slot before any match returns hit = 0.
- R6: An insert that finds no empty slot in 512 probes returns status 1 (full) and leaves the table unchanged.
- R7: A lookup that probes all 512 slots without a match returns hit = 0.
- R8: A request whose handle is zero is answered at once, without probing. A lookup returns hit = 0 and an insert returns status 2 (bad handle).
- R9: Each probe takes two clocks: one for the RAM read and one for the compare. An answer after k probes appears 2k clocks after the accepting edge, and an answer without probes appears right after that edge. The done output is a one-clock pulse.
- R10: Only one request is in flight at a time, and both ready outputs stay low while it is. When both ports are valid in the same cycle the lookup is accepted first.
- R11: After reset the block spends 512 clocks clearing every slot, with both readies low. After that, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_handle | input | 32 | Handle to look up |
| lk_chan | input | 5 | Channel of the lookup |
| lk_done | output | 1 | Lookup answer pulse |
| lk_hit | output | 1 | Lookup found the handle |
| lk_ctx | output | 32 | Context word of the hit, zero on a miss |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request can be accepted |
| ins_handle | input | 32 | Handle to register |
| ins_chan | input | 5 | Channel of the new entry |
| ins_inst | input | 16 | Instance address (in 16-byte units) |
| ins_engine | input | 2 | Engine number |
| ins_done | output | 1 | Insert answer pulse |
| ins_status | output | 2 | 0 ok, 1 full, 2 bad handle |

## Verification
Some properties are checked on every cycle:
- a zero handle is answered on the next clock;
- the two done pulses never coincide;
- accepting a real request drops both readies;
- every answer arrives an odd number of clocks after acceptance and within the 512-probe bound;
- a full answer comes only after the complete sweep;
- in the default layout a hit carries the valid flag and the requesting channel.

Other behaviour can only be shown by the bench's scenarios, because it depends on the table contents:
- where the hash places each handle;
- collision chains and wrap from slot 511 to slot 0;
- the exact context word returned;
- that a full table stays unchanged;
- that the table is empty after the reset clear.

// File: rtl/ohl_pkg.sv
package ohl_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_READ  = 2'd2,
    ST_CHECK = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    INS_OK   = 2'd0,
    INS_FULL = 2'd1,
    INS_ZERO = 2'd2
  } ins_status_e;

  // context word layouts
  localparam int LAYOUT_CHAN = 0;   // valid flag + channel field
  localparam int LAYOUT_WIDE = 1;   // engine moved up, no channel field

  localparam int CTX_CHAN_LSB   = 24;
  localparam int CTX_ENG_LSB_CH = 16;
  localparam int CTX_ENG_LSB_WD = 20;
endpackage

// File: rtl/ohl_hash_fold.sv
module ohl_hash_fold #(
  parameter int IDX_W      = 9,
  parameter int HANDLE_W   = 32,
  parameter int CHAN_W     = 5,
  parameter int CHAN_SHIFT = 5
) (
  input  logic [HANDLE_W-1:0] handle,
  input  logic [CHAN_W-1:0]   chan,
  output logic [IDX_W-1:0]    idx
);
  localparam int CHUNKS = (HANDLE_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;
  localparam int CW_W   = IDX_W + CHAN_W + CHAN_SHIFT;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] partial [CHUNKS+1];
  logic [CW_W-1:0]  chan_wide;

  assign padded     = PAD_W'(handle);
  assign partial[0] = '0;

  for (genvar g = 0; g < CHUNKS; g++) begin : g_fold
    assign partial[g+1] = partial[g] ^ padded[g*IDX_W +: IDX_W];
  end

  assign chan_wide = CW_W'(chan) << CHAN_SHIFT;
  assign idx       = partial[CHUNKS] ^ chan_wide[IDX_W-1:0];
endmodule

// File: rtl/ohl_ctx_pack.sv
module ohl_ctx_pack #(
  parameter int CTX_W  = 32,
  parameter int CHAN_W = 5,
  parameter int INST_W = 16,
  parameter int ENG_W  = 2,
  parameter int LAYOUT = 0
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [INST_W-1:0] inst,
  input  logic [ENG_W-1:0]  engine,
  output logic [CTX_W-1:0]  ctx
);
  import ohl_pkg::*;

  if (LAYOUT == LAYOUT_CHAN) begin : g_chan_layout
    always_comb begin
      ctx = '0;
      ctx[CTX_W-1]                    = 1'b1;
      ctx[CTX_CHAN_LSB +: CHAN_W]     = chan;
      ctx[CTX_ENG_LSB_CH +: ENG_W]    = engine;
      ctx[0 +: INST_W]                = inst;
    end
  end else begin : g_wide_layout
    logic unused_chan;
    assign unused_chan = ^chan;
    always_comb begin
      ctx = '0;
      ctx[CTX_ENG_LSB_WD +: ENG_W]    = engine;
      ctx[0 +: INST_W]                = inst;
    end
  end
endmodule

// File: rtl/ohl_slot_ram.sv
module ohl_slot_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ohl_probe_ctrl.sv
module ohl_probe_ctrl #(
  parameter int IDX_W    = 9,
  parameter int HANDLE_W = 32,
  parameter int CHAN_W   = 5,
  parameter int CTX_W    = 32,
  parameter int LAYOUT   = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  logic [HANDLE_W-1:0]       lk_handle,
  input  logic [CHAN_W-1:0]         lk_chan,
  input  logic                      ins_valid,
  input  logic [HANDLE_W-1:0]       ins_handle,
  input  logic [CHAN_W-1:0]         ins_chan,
  input  logic [CTX_W-1:0]          ins_ctx,
  input  logic [IDX_W-1:0]          hash_idx,
  input  logic [HANDLE_W+CTX_W-1:0] ram_rdata,
  output logic                      ready,
  output logic                      ram_we,
  output logic [IDX_W-1:0]          ram_waddr,
  output logic [HANDLE_W+CTX_W-1:0] ram_wdata,
  output logic [IDX_W-1:0]          ram_raddr,
  output logic                      lk_done,
  output logic                      lk_hit,
  output logic [CTX_W-1:0]          lk_ctx,
  output logic                      ins_done,
  output logic [1:0]                ins_status
);
  import ohl_pkg::*;

  localparam int SLOTS = 1 << IDX_W;
  localparam logic [IDX_W:0] LAST_PROBE = (IDX_W+1)'(SLOTS - 1);

  state_e               state;
  ins_status_e          status_q;
  logic [IDX_W-1:0]     probe_idx;
  logic [IDX_W-1:0]     clr_idx;
  logic [IDX_W:0]       probe_cnt;
  logic                 op_ins;
  logic [HANDLE_W-1:0]  key_handle;
  logic [CHAN_W-1:0]    key_chan;
  logic [CTX_W-1:0]     key_ctx;

  logic [HANDLE_W-1:0]  ent_handle;
  logic [CTX_W-1:0]     ent_ctx;
  logic                 slot_empty;
  logic                 chan_ok;
  logic                 hit_now;
  logic                 last_probe;
  logic                 take_lk;
  logic                 take_ins;

  assign ent_handle = ram_rdata[CTX_W +: HANDLE_W];
  assign ent_ctx    = ram_rdata[CTX_W-1:0];
  assign slot_empty = (ent_handle == '0);
  assign last_probe = (probe_cnt == LAST_PROBE);

  if (LAYOUT == LAYOUT_CHAN) begin : g_chan_match
    assign chan_ok = (ent_ctx[CTX_CHAN_LSB +: CHAN_W] == key_chan);
  end else begin : g_handle_match
    assign chan_ok = 1'b1;
  end

  assign hit_now  = !slot_empty && (ent_handle == key_handle) && chan_ok;
  assign ready    = (state == ST_IDLE);
  assign take_lk  = ready && lk_valid;
  assign take_ins = ready && !lk_valid && ins_valid;

  assign ram_raddr  = probe_idx;
  assign ram_we     = (state == ST_CLEAR) ||
                      ((state == ST_CHECK) && op_ins && slot_empty);
  assign ram_waddr  = (state == ST_CLEAR) ? clr_idx : probe_idx;
  assign ram_wdata  = (state == ST_CLEAR) ? '0 : {key_handle, key_ctx};
  assign ins_status = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      status_q   <= INS_OK;
      clr_idx    <= '0;
      probe_idx  <= '0;
      probe_cnt  <= '0;
      op_ins     <= 1'b0;
      key_handle <= '0;
      key_chan   <= '0;
      key_ctx    <= '0;
      lk_done    <= 1'b0;
      lk_hit     <= 1'b0;
      lk_ctx     <= '0;
      ins_done   <= 1'b0;
    end else begin
      lk_done  <= 1'b0;
      ins_done <= 1'b0;
      case (state)
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == '1) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (take_lk) begin
            key_handle <= lk_handle;
            key_chan   <= lk_chan;
            op_ins     <= 1'b0;
            probe_idx  <= hash_idx;
            probe_cnt  <= '0;
            if (lk_handle == '0) begin
              lk_done <= 1'b1;
              lk_hit  <= 1'b0;
              lk_ctx  <= '0;
            end else begin
              state <= ST_READ;
            end
          end else if (take_ins) begin
            key_handle <= ins_handle;
            key_chan   <= ins_chan;
            key_ctx    <= ins_ctx;
            op_ins     <= 1'b1;
            probe_idx  <= hash_idx;
            probe_cnt  <= '0;
            if (ins_handle == '0) begin
              ins_done <= 1'b1;
              status_q <= INS_ZERO;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_READ: state <= ST_CHECK;
        ST_CHECK: begin
          if (!op_ins) begin
            if (hit_now) begin
              lk_done <= 1'b1;
              lk_hit  <= 1'b1;
              lk_ctx  <= ent_ctx;
              state   <= ST_IDLE;
            end else if (slot_empty || last_probe) begin
              lk_done <= 1'b1;
              lk_hit  <= 1'b0;
              lk_ctx  <= '0;
              state   <= ST_IDLE;
            end else begin
              probe_idx <= probe_idx + 1'b1;
              probe_cnt <= probe_cnt + 1'b1;
              state     <= ST_READ;
            end
          end else begin
            if (slot_empty) begin
              ins_done <= 1'b1;
              status_q <= INS_OK;
              state    <= ST_IDLE;
            end else if (last_probe) begin
              ins_done <= 1'b1;
              status_q <= INS_FULL;
              state    <= ST_IDLE;
            end else begin
              probe_idx <= probe_idx + 1'b1;
              probe_cnt <= probe_cnt + 1'b1;
              state     <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/obj_hash_lookup.sv
module obj_hash_lookup #(
  parameter int IDX_W    = 9,
  parameter int HANDLE_W = 32,
  parameter int CHAN_W   = 5,
  parameter int INST_W   = 16,
  parameter int ENG_W    = 2,
  parameter int CTX_W    = 32,
  parameter int LAYOUT   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [HANDLE_W-1:0] lk_handle,
  input  logic [CHAN_W-1:0]   lk_chan,
  output logic                lk_done,
  output logic                lk_hit,
  output logic [CTX_W-1:0]    lk_ctx,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [HANDLE_W-1:0] ins_handle,
  input  logic [CHAN_W-1:0]   ins_chan,
  input  logic [INST_W-1:0]   ins_inst,
  input  logic [ENG_W-1:0]    ins_engine,
  output logic                ins_done,
  output logic [1:0]          ins_status
);
  localparam int ENTRY_W    = HANDLE_W + CTX_W;
  localparam int CHAN_SHIFT = IDX_W - 4;

  logic [HANDLE_W-1:0] sel_handle;
  logic [CHAN_W-1:0]   sel_chan;
  logic [IDX_W-1:0]    hash_idx;
  logic [CTX_W-1:0]    new_ctx;
  logic                ready;
  logic                ram_we;
  logic [IDX_W-1:0]    ram_waddr;
  logic [IDX_W-1:0]    ram_raddr;
  logic [ENTRY_W-1:0]  ram_wdata;
  logic [ENTRY_W-1:0]  ram_rdata;

  // lookup has priority for the hash input, matching the controller
  assign sel_handle = lk_valid ? lk_handle : ins_handle;
  assign sel_chan   = lk_valid ? lk_chan   : ins_chan;
  assign lk_ready   = ready;
  assign ins_ready  = ready;

  ohl_hash_fold #(
    .IDX_W(IDX_W), .HANDLE_W(HANDLE_W), .CHAN_W(CHAN_W), .CHAN_SHIFT(CHAN_SHIFT)
  ) i_hash (
    .handle(sel_handle), .chan(sel_chan), .idx(hash_idx)
  );

  ohl_ctx_pack #(
    .CTX_W(CTX_W), .CHAN_W(CHAN_W), .INST_W(INST_W), .ENG_W(ENG_W), .LAYOUT(LAYOUT)
  ) i_pack (
    .chan(ins_chan), .inst(ins_inst), .engine(ins_engine), .ctx(new_ctx)
  );

  ohl_probe_ctrl #(
    .IDX_W(IDX_W), .HANDLE_W(HANDLE_W), .CHAN_W(CHAN_W), .CTX_W(CTX_W), .LAYOUT(LAYOUT)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_handle(lk_handle), .lk_chan(lk_chan),
    .ins_valid(ins_valid), .ins_handle(ins_handle), .ins_chan(ins_chan),
    .ins_ctx(new_ctx), .hash_idx(hash_idx), .ram_rdata(ram_rdata),
    .ready(ready), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ctx(lk_ctx),
    .ins_done(ins_done), .ins_status(ins_status)
  );

  ohl_slot_ram #(
    .ADDR_W(IDX_W), .DATA_W(ENTRY_W)
  ) i_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/ohl_checker.sv
module ohl_checker #(
  parameter int IDX_W    = 9,
  parameter int HANDLE_W = 32,
  parameter int CHAN_W   = 5,
  parameter int CTX_W    = 32,
  parameter int LAYOUT   = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                lk_valid,
  input logic                lk_ready,
  input logic [HANDLE_W-1:0] lk_handle,
  input logic [CHAN_W-1:0]   lk_chan,
  input logic                lk_done,
  input logic                lk_hit,
  input logic [CTX_W-1:0]    lk_ctx,
  input logic                ins_valid,
  input logic                ins_ready,
  input logic [HANDLE_W-1:0] ins_handle,
  input logic                ins_done,
  input logic [1:0]          ins_status
);
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [31:0] MAX_LAT = 32'(2 * SLOTS + 1);

  logic        took_lk, took_ins, took_real, done_now;
  logic [31:0] lat_cnt;
  logic [CHAN_W-1:0] cap_chan;

  assign took_lk   = lk_valid && lk_ready;
  assign took_ins  = ins_valid && ins_ready && !lk_valid;
  assign took_real = (took_lk && lk_handle != '0) || (took_ins && ins_handle != '0);
  assign done_now  = lk_done || ins_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt  <= '0;
      cap_chan <= '0;
    end else begin
      if (took_lk) cap_chan <= lk_chan;
      if (took_lk || took_ins) lat_cnt <= 32'd1;
      else if (done_now)       lat_cnt <= '0;
      else if (lat_cnt != '0)  lat_cnt <= lat_cnt + 32'd1;
    end
  end

  assert_zero_lookup_R8: assert property (@(posedge clk) disable iff (rst)
    (took_lk && lk_handle == '0) |=> (lk_done && !lk_hit));

  assert_zero_insert_R8: assert property (@(posedge clk) disable iff (rst)
    (took_ins && ins_handle == '0) |=> (ins_done && ins_status == 2'd2));

  assert_one_answer_R10: assert property (@(posedge clk) disable iff (rst)
    !(lk_done && ins_done));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    took_real |=> (!lk_ready && !ins_ready));

  assert_latency_bound_R9: assert property (@(posedge clk) disable iff (rst)
    lat_cnt <= MAX_LAT);

  assert_latency_odd_R9: assert property (@(posedge clk) disable iff (rst)
    done_now |-> lat_cnt[0]);

  assert_full_after_sweep_R6: assert property (@(posedge clk) disable iff (rst)
    (ins_done && ins_status == 2'd1) |-> (lat_cnt == MAX_LAT));

  if (LAYOUT == 0) begin : g_chan_chk
    assert_hit_channel_R4: assert property (@(posedge clk) disable iff (rst)
      (lk_done && lk_hit) |-> (lk_ctx[CTX_W-1] && lk_ctx[24 +: CHAN_W] == cap_chan));
  end
endmodule

bind obj_hash_lookup ohl_checker #(
  .IDX_W(IDX_W), .HANDLE_W(HANDLE_W), .CHAN_W(CHAN_W), .CTX_W(CTX_W), .LAYOUT(LAYOUT)
) i_checker (.*);

// File: tb/test_obj_hash_lookup.sv
module test_obj_hash_lookup;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_ins;
    logic [31:0] h;
    logic [4:0]  c;
    logic [15:0] inst;
    logic [1:0]  eng;
    logic [1:0]  res;   // lookup: 1 hit / 0 miss; insert: status code
    logic [15:0] lat;   // 2*probes + 1, or 1 with no probe
  } vec_t;

  // collision chains at slot 1 (R1), wrap 511 -> 0 (R3), channel mixing (R1)
  localparam vec_t VECS [17] = '{
    '{1'b1, 32'h0000_0001, 5'd0, 16'h0010, 2'd1, 2'd0, 16'd3},
    '{1'b1, 32'h0000_0200, 5'd0, 16'h0020, 2'd1, 2'd0, 16'd5},
    '{1'b1, 32'h0004_0000, 5'd0, 16'h0030, 2'd2, 2'd0, 16'd7},
    '{1'b0, 32'h0004_0000, 5'd0, 16'h0030, 2'd2, 2'd1, 16'd7},
    '{1'b0, 32'h0000_0001, 5'd0, 16'h0010, 2'd1, 2'd1, 16'd3},
    '{1'b0, 32'h0000_0400, 5'd0, 16'h0000, 2'd0, 2'd0, 16'd7},
    '{1'b1, 32'h0000_01FF, 5'd0, 16'h0040, 2'd1, 2'd0, 16'd3},
    '{1'b1, 32'h0003_FE00, 5'd0, 16'h0050, 2'd3, 2'd0, 16'd5},
    '{1'b0, 32'h0003_FE00, 5'd0, 16'h0050, 2'd3, 2'd1, 16'd5},
    '{1'b1, 32'h0000_0005, 5'd3, 16'h0060, 2'd1, 2'd0, 16'd3},
    '{1'b0, 32'h0000_0005, 5'd3, 16'h0060, 2'd1, 2'd1, 16'd3},
    '{1'b0, 32'h0000_0005, 5'd0, 16'h0000, 2'd0, 2'd0, 16'd3},
    '{1'b1, 32'h0000_0000, 5'd0, 16'h0000, 2'd0, 2'd2, 16'd1},
    '{1'b0, 32'h0000_0000, 5'd0, 16'h0000, 2'd0, 2'd0, 16'd1},
    '{1'b0, 32'h0000_0001, 5'd2, 16'h0000, 2'd0, 2'd0, 16'd3},
    '{1'b1, 32'h0000_0040, 5'd2, 16'h0070, 2'd1, 2'd0, 16'd11},
    '{1'b0, 32'h0000_0040, 5'd2, 16'h0070, 2'd1, 2'd1, 16'd11}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, ins_valid = 1'b0;
  logic [31:0] lk_handle = '0, ins_handle = '0;
  logic [4:0]  lk_chan = '0, ins_chan = '0;
  logic [15:0] ins_inst = '0;
  logic [1:0]  ins_engine = '0;
  logic        lk_ready, ins_ready, lk_done, lk_hit, ins_done;
  logic [31:0] lk_ctx;
  logic [1:0]  ins_status;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cycles = 0;

  obj_hash_lookup i_obj_hash_lookup (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_handle(lk_handle), .lk_chan(lk_chan),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ctx(lk_ctx),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_handle(ins_handle),
    .ins_chan(ins_chan), .ins_inst(ins_inst), .ins_engine(ins_engine),
    .ins_done(ins_done), .ins_status(ins_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_ctx(input logic [4:0] c, input logic [15:0] i,
                                          input logic [1:0] e);
    return {1'b1, 2'b00, c, 6'b0, e, i};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic is_ins, input logic [31:0] h, input logic [4:0] c,
                       input logic [15:0] inst, input logic [1:0] eng,
                       output int lat, output logic hit, output logic [31:0] ctx,
                       output logic [1:0] st);
    @(negedge clk);
    if (is_ins) begin
      ins_valid = 1'b1; ins_handle = h; ins_chan = c; ins_inst = inst; ins_engine = eng;
    end else begin
      lk_valid = 1'b1; lk_handle = h; lk_chan = c;
    end
    while (!(is_ins ? ins_ready : lk_ready)) @(negedge clk);
    @(posedge clk); #1;
    lk_valid = 1'b0; ins_valid = 1'b0;
    lat = 1;
    while (!(lk_done || ins_done) && lat < 3000) begin
      @(posedge clk); #1; lat++;
    end
    hit = lk_hit; ctx = lk_ctx; st = ins_status;
  endtask

  task automatic do_reset(output int clr_cycles);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!lk_ready && !ins_ready && !lk_done && !ins_done, "R11 reset outputs",
        {lk_ready, ins_ready, lk_done, ins_done}, 0);
    @(negedge clk); rst = 1'b0;
    clr_cycles = 0;
    while (!lk_ready && clr_cycles < 2000) begin
      @(posedge clk); #1; clr_cycles++;
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      n_cycles++;
      if (n_cycles > 150000) begin
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d cycles expected below 150000", n_cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int lat, clr;
    logic hit;
    logic [31:0] ctx;
    logic [1:0] st;
    int fill_bad;

    // reset and table clear
    do_reset(clr);
    chk(clr == 512, "R11 clear length", clr, 512);
    do_op(1'b0, 32'h1, 5'd0, '0, '0, lat, hit, ctx, st);
    chk(!hit && lat == 3, "R11 empty after clear", {hit, 32'(lat)}, 3);

    // vector table
    for (int v = 0; v < 17; v++) begin
      do_op(VECS[v].is_ins, VECS[v].h, VECS[v].c, VECS[v].inst, VECS[v].eng,
            lat, hit, ctx, st);
      chk(lat == int'(VECS[v].lat), "R1 R9 probe latency", lat, VECS[v].lat);
      if (VECS[v].is_ins) begin
        chk(st == VECS[v].res, (VECS[v].res == 2'd2) ? "R8 insert status" : "R3 insert status",
            st, VECS[v].res);
      end else begin
        chk(hit == VECS[v].res[0],
            (VECS[v].h == 0) ? "R8 zero lookup" : (VECS[v].res[0] ? "R4 hit" : "R5 miss"),
            hit, VECS[v].res[0]);
        if (VECS[v].res[0])
          chk(ctx == exp_ctx(VECS[v].c, VECS[v].inst, VECS[v].eng), "R2 R4 context word",
              ctx, exp_ctx(VECS[v].c, VECS[v].inst, VECS[v].eng));
      end
    end

    // R10: both ports valid together, lookup goes first
    @(negedge clk);
    lk_valid = 1'b1; lk_handle = 32'h0;
    ins_valid = 1'b1; ins_handle = 32'h777; ins_chan = 5'd0; ins_inst = 16'h0080; ins_engine = 2'd1;
    @(posedge clk); #1;
    lk_valid = 1'b0;
    chk(lk_done && !ins_done, "R10 lookup priority", {lk_done, ins_done}, 2'b10);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    lat = 1;
    while (!ins_done && lat < 3000) begin @(posedge clk); #1; lat++; end
    chk(ins_status == 2'd0 && lat == 3, "R10 deferred insert", {ins_status, 32'(lat)}, 3);
    do_op(1'b0, 32'h777, 5'd0, '0, '0, lat, hit, ctx, st);
    chk(hit && ctx == exp_ctx(5'd0, 16'h0080, 2'd1), "R10 deferred insert stored", ctx,
        exp_ctx(5'd0, 16'h0080, 2'd1));

    // full table
    do_reset(clr);
    fill_bad = 0;
    for (int k = 1; k < 512; k++) begin
      do_op(1'b1, 32'(k), 5'd0, 16'(k), 2'd1, lat, hit, ctx, st);
      if (st != 2'd0 || lat != 3) fill_bad++;
    end
    do_op(1'b1, 32'h201, 5'd0, 16'h0201, 2'd1, lat, hit, ctx, st);
    if (st != 2'd0 || lat != 3) fill_bad++;
    chk(fill_bad == 0, "R1 R3 fill distinct slots", fill_bad, 0);
    do_op(1'b1, 32'h8000_0000, 5'd0, 16'h0abc, 2'd1, lat, hit, ctx, st);
    chk(st == 2'd1, "R6 full status", st, 1);
    chk(lat == 1025, "R6 full sweep latency", lat, 1025);
    do_op(1'b0, 32'h8000_0000, 5'd0, '0, '0, lat, hit, ctx, st);
    chk(!hit && lat == 1025, "R6 R7 nothing written, sweep miss", {hit, 32'(lat)}, 1025);
    do_op(1'b0, 32'h100, 5'd0, '0, '0, lat, hit, ctx, st);
    chk(hit && ctx == exp_ctx(5'd0, 16'h0100, 2'd1), "R4 hit in full table", ctx,
        exp_ctx(5'd0, 16'h0100, 2'd1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule